// File: doc/BRIEF.md
# Dual Halfword Multiply Add/Subtract Unit

This unit reads each of two 32-bit operands as a pair of signed 16-bit halfwords: the low half in bits [15:0] and the high half in bits [31:16]. It forms two signed 16x16 products and either sums them or takes their difference. The result is one 32-bit value.

An exchange select swaps the two halves of the second operand before the products are formed. The two products therefore pair like halves, or cross-pair them. Each product is sign-extended to 32 bits before it is combined.

The result is registered and appears one clock after an accepted input, together with a result-valid strobe. A sticky flag records any signed 32-bit overflow of a sum. Only a dedicated clear input resets that flag. Surrounding logic supplies operands with a valid strobe and reads the result when the strobe comes back.

Top module: `dual_hmul_combine`

## Requirements
- R1: While reset is asserted, and at the first sample after it is released, `res_valid` and `ovf_sticky` are 0.
- R2: With `sub_sel`=0 and `xchg_sel`=0, `res_data` equals A[15:0]*B[15:0] + A[31:16]*B[31:16]. All halves are signed 16-bit and the sum is taken modulo 2^32.
- R3: With `sub_sel`=0 and `xchg_sel`=1, `res_data` equals A[15:0]*B[31:16] + A[31:16]*B[15:0].
- R4: With `sub_sel`=1 and `xchg_sel`=0, `res_data` equals A[15:0]*B[15:0] - A[31:16]*B[31:16].
- R5: With `sub_sel`=1 and `xchg_sel`=1, `res_data` equals A[15:0]*B[31:16] - A[31:16]*B[15:0].
- R6: `res_valid` is 1 exactly in the cycle after a cycle in which `in_valid` was 1. `res_data` carries that input's result in the same cycle.
- R7: A cycle with `in_valid`=0 leaves `res_data` unchanged and does not set `ovf_sticky`, whatever is on the operand and select inputs.
- R8: An accepted sum whose signed 32-bit value overflows sets `ovf_sticky` on the edge that registers the result. The only such case is both products equal to (-32768)*(-32768), and `res_data` then wraps to 32'h80000000.
- R9: Once set, `ovf_sticky` stays 1 through later non-overflowing operations until `ovf_clear` is applied.
- R10: `ovf_clear`=1 drives `ovf_sticky` to 0 on the next edge. If an overflowing sum is accepted in the same cycle, the set wins and the flag reads 1.
- R11: An accepted difference never sets `ovf_sticky`, even with the most extreme operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operands and selects are accepted in this cycle |
| op_a | input | 32 | First operand, two signed halfwords |
| op_b | input | 32 | Second operand, two signed halfwords |
| sub_sel | input | 1 | 0: sum of products, 1: low-lane minus high-lane product |
| xchg_sel | input | 1 | 1: swap halves of `op_b` before multiplying |
| ovf_clear | input | 1 | Clears the sticky overflow flag |
| res_data | output | 32 | Registered result |
| res_valid | output | 1 | Result valid, one clock after acceptance |
| ovf_sticky | output | 1 | Sticky signed-overflow flag |

## Verification
The flag's clear request and a new overflow set can land on the same clock edge. The bench provokes this by raising `ovf_clear` in the very cycle that it presents the overflowing operand pair 32'h80008000 with an accepted sum. The flag must read 1 afterwards, because the set takes priority over the clear. The same clear, paired with a non-overflowing sum or with no accepted input, must leave the flag at 0.

// File: rtl/dhm_pkg.sv
package dhm_pkg;

  // How the two lane products are combined.
  typedef enum logic {
    CMB_ADD = 1'b0,
    CMB_SUB = 1'b1
  } cmb_op_e;

  // Lane indices used across the datapath: the lane pairing the low half
  // of A, and the lane pairing the high half of A.
  localparam int LANE_LO = 0;
  localparam int LANE_HI = 1;
  localparam int N_LANES = 2;

endpackage

// File: rtl/dhm_route.sv
// Splits both operands into signed halfword lanes and applies the
// optional half exchange on the second operand.
module dhm_route #(
  parameter  int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic [WORD_W-1:0]                      op_a,
  input  logic [WORD_W-1:0]                      op_b,
  input  logic                                   xchg_sel,
  output logic [dhm_pkg::N_LANES-1:0][HALF_W-1:0] a_lane,
  output logic [dhm_pkg::N_LANES-1:0][HALF_W-1:0] b_lane
);

  logic [HALF_W-1:0] b_low;
  logic [HALF_W-1:0] b_high;

  always_comb begin
    b_low  = op_b[HALF_W-1:0];
    b_high = op_b[WORD_W-1:HALF_W];
  end

  always_comb begin
    a_lane[dhm_pkg::LANE_LO] = op_a[HALF_W-1:0];
    a_lane[dhm_pkg::LANE_HI] = op_a[WORD_W-1:HALF_W];
    if (xchg_sel) begin
      b_lane[dhm_pkg::LANE_LO] = b_high;
      b_lane[dhm_pkg::LANE_HI] = b_low;
    end else begin
      b_lane[dhm_pkg::LANE_LO] = b_low;
      b_lane[dhm_pkg::LANE_HI] = b_high;
    end
  end

endmodule

// File: rtl/dhm_mul_pair.sv
// One signed HALF_W x HALF_W multiplier per lane, each product
// sign-extended to the full word width.
module dhm_mul_pair #(
  parameter  int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic [dhm_pkg::N_LANES-1:0][HALF_W-1:0] a_lane,
  input  logic [dhm_pkg::N_LANES-1:0][HALF_W-1:0] b_lane,
  output logic [dhm_pkg::N_LANES-1:0][WORD_W-1:0] prod
);

  for (genvar g = 0; g < dhm_pkg::N_LANES; g++) begin : g_lane
    logic signed [WORD_W-1:0] a_ext;
    logic signed [WORD_W-1:0] b_ext;
    logic signed [WORD_W-1:0] p_full;

    always_comb begin
      a_ext  = {{HALF_W{a_lane[g][HALF_W-1]}}, a_lane[g]};
      b_ext  = {{HALF_W{b_lane[g][HALF_W-1]}}, b_lane[g]};
      // The product of two sign-extended halves fits in WORD_W bits.
      p_full = a_ext * b_ext;
    end

    assign prod[g] = p_full;
  end

endmodule

// File: rtl/dhm_combine.sv
// Adds or subtracts the two lane products and flags signed overflow
// of a sum.
module dhm_combine #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] prod_lo,
  input  logic [WORD_W-1:0] prod_hi,
  input  dhm_pkg::cmb_op_e  mode,
  output logic [WORD_W-1:0] value,
  output logic              ovf
);

  localparam int MSB = WORD_W - 1;

  logic [WORD_W-1:0] sum_w;
  logic [WORD_W-1:0] diff_w;
  logic              sum_ovf;

  always_comb begin
    sum_w  = prod_lo + prod_hi;
    diff_w = prod_lo - prod_hi;
    // A sum overflows when both addends share a sign that the sum lacks.
    sum_ovf = (prod_lo[MSB] == prod_hi[MSB]) && (sum_w[MSB] != prod_lo[MSB]);
  end

  always_comb begin
    unique case (mode)
      dhm_pkg::CMB_SUB: begin
        value = diff_w;
        // The difference of two halfword products always fits.
        ovf   = 1'b0;
      end
      default: begin
        value = sum_w;
        ovf   = sum_ovf;
      end
    endcase
  end

endmodule

// File: rtl/dual_hmul_combine.sv
// Registered dual halfword multiply with add or subtract of the products.
module dual_hmul_combine #(
  parameter  int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              sub_sel,
  input  logic              xchg_sel,
  input  logic              ovf_clear,
  output logic [WORD_W-1:0] res_data,
  output logic              res_valid,
  output logic              ovf_sticky
);

  import dhm_pkg::*;

  logic [N_LANES-1:0][HALF_W-1:0] a_lane;
  logic [N_LANES-1:0][HALF_W-1:0] b_lane;
  logic [N_LANES-1:0][WORD_W-1:0] prod;
  cmb_op_e                        mode;
  logic [WORD_W-1:0]              comb_value;
  logic                           comb_ovf;

  logic [WORD_W-1:0] data_q, data_d;
  logic              valid_q, valid_d;
  logic              flag_q, flag_d;
  logic              data_en;

  assign mode = sub_sel ? CMB_SUB : CMB_ADD;

  dhm_route #(.HALF_W(HALF_W)) u_route (
    .op_a     (op_a),
    .op_b     (op_b),
    .xchg_sel (xchg_sel),
    .a_lane   (a_lane),
    .b_lane   (b_lane)
  );

  dhm_mul_pair #(.HALF_W(HALF_W)) u_mul (
    .a_lane (a_lane),
    .b_lane (b_lane),
    .prod   (prod)
  );

  dhm_combine #(.WORD_W(WORD_W)) u_comb (
    .prod_lo (prod[LANE_LO]),
    .prod_hi (prod[LANE_HI]),
    .mode    (mode),
    .value   (comb_value),
    .ovf     (comb_ovf)
  );

  // Next-state logic
  always_comb begin
    data_en = in_valid;
    data_d  = comb_value;
    valid_d = in_valid;
    // A fresh overflow outranks a clear in the same cycle.
    flag_d  = (flag_q & ~ovf_clear) | (in_valid & comb_ovf);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      flag_q  <= flag_d;
    end
  end

  // The datapath register needs no reset; valid qualifies it.
  always_ff @(posedge clk) begin
    if (data_en) begin
      data_q <= data_d;
    end
  end

  assign res_data   = data_q;
  assign res_valid  = valid_q;
  assign ovf_sticky = flag_q;

endmodule

// File: rtl/dhm_checker.sv
module dhm_checker #(
  parameter  int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] op_a,
  input logic [WORD_W-1:0] op_b,
  input logic              sub_sel,
  input logic              ovf_clear,
  input logic [WORD_W-1:0] res_data,
  input logic              res_valid,
  input logic              ovf_sticky
);

  localparam logic [HALF_W-1:0] MIN_HALF = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] MIN_PAIR = {MIN_HALF, MIN_HALF};
  localparam logic [WORD_W-1:0] MIN_WORD = {1'b1, {(WORD_W-1){1'b0}}};

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);

  // R6
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_data));

  // R8
  min_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sub_sel && op_a == MIN_PAIR && op_b == MIN_PAIR)
      |=> (ovf_sticky && res_data == MIN_WORD));

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sticky && !ovf_clear) |=> ovf_sticky);

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clear && !(in_valid && !sub_sel)) |=> !ovf_sticky);

  // R11
  no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_sticky && (!in_valid || sub_sel)) |=> !ovf_sticky);

endmodule

bind dual_hmul_combine dhm_checker #(.HALF_W(HALF_W)) u_dhm_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .op_a       (op_a),
  .op_b       (op_b),
  .sub_sel    (sub_sel),
  .ovf_clear  (ovf_clear),
  .res_data   (res_data),
  .res_valid  (res_valid),
  .ovf_sticky (ovf_sticky)
);

// File: tb/dual_hmul_combine_test.sv
module dual_hmul_combine_test;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] op_a;
  logic [31:0] op_b;
  logic        sub_sel;
  logic        xchg_sel;
  logic        ovf_clear;
  logic [31:0] res_data;
  logic        res_valid;
  logic        ovf_sticky;

  int n_checks;
  int n_fail;

  dual_hmul_combine uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_a       (op_a),
    .op_b       (op_b),
    .sub_sel    (sub_sel),
    .xchg_sel   (xchg_sel),
    .ovf_clear  (ovf_clear),
    .res_data   (res_data),
    .res_valid  (res_valid),
    .ovf_sticky (ovf_sticky)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected result from the requirement equations.
  function automatic logic [31:0] expect_val(logic [31:0] a, logic [31:0] b,
                                             logic sub, logic x);
    logic signed [15:0] al, ah, bl, bh;
    logic signed [31:0] p0, p1;
    al = a[15:0];
    ah = a[31:16];
    bl = x ? b[31:16] : b[15:0];
    bh = x ? b[15:0]  : b[31:16];
    p0 = al * bl;
    p1 = ah * bh;
    return sub ? (p0 - p1) : (p0 + p1);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Present one input for one edge; returns just after that edge.
  task automatic issue(logic [31:0] a, logic [31:0] b, logic sub, logic x,
                       logic vld, logic clr);
    @(negedge clk);
    op_a = a; op_b = b; sub_sel = sub; xchg_sel = x;
    in_valid = vld; ovf_clear = clr;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    ovf_clear = 1'b0;
  endtask

  task automatic run_op(string req, logic [31:0] a, logic [31:0] b,
                        logic sub, logic x);
    issue(a, b, sub, x, 1'b1, 1'b0);
    chk(req, "result", res_data, expect_val(a, b, sub, x));
    chk("R6", "valid after accept", {31'b0, res_valid}, 32'd1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0;
    sub_sel = 1'b0; xchg_sel = 1'b0; ovf_clear = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "valid in reset", {31'b0, res_valid}, 32'd0);
    chk("R1", "flag in reset", {31'b0, ovf_sticky}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", "valid after release", {31'b0, res_valid}, 32'd0);
    chk("R1", "flag after release", {31'b0, ovf_sticky}, 32'd0);
  endtask

  task automatic t_add_plain();
    run_op("R2", 32'h0003_0002, 32'h0005_0004, 1'b0, 1'b0);
    chk("R2", "small sum", res_data, 32'd23);
    run_op("R2", 32'hFFFF_0007, 32'h0002_0003, 1'b0, 1'b0);
    run_op("R2", 32'h7FFF_7FFF, 32'h7FFF_7FFF, 1'b0, 1'b0);
    chk("R2", "max positive no flag", {31'b0, ovf_sticky}, 32'd0);
    run_op("R2", 32'h8000_7FFF, 32'h7FFF_8000, 1'b0, 1'b0);
  endtask

  task automatic t_add_xchg();
    run_op("R3", 32'h0003_0002, 32'h0005_0004, 1'b0, 1'b1);
    chk("R3", "cross sum", res_data, 32'd22);
    run_op("R3", 32'hFFFE_1234, 32'h8001_00FF, 1'b0, 1'b1);
  endtask

  task automatic t_sub_plain();
    run_op("R4", 32'h0003_0002, 32'h0005_0004, 1'b0 | 1'b1, 1'b0);
    chk("R4", "small diff", res_data, 32'hFFFF_FFF9);
    run_op("R4", 32'h8000_0001, 32'h0001_FFFF, 1'b1, 1'b0);
  endtask

  task automatic t_sub_xchg();
    run_op("R5", 32'h0003_0002, 32'h0005_0004, 1'b1, 1'b1);
    chk("R5", "cross diff", res_data, 32'hFFFF_FFFE);
    run_op("R5", 32'h7FFF_8000, 32'hC000_0100, 1'b1, 1'b1);
  endtask

  task automatic t_hold();
    logic [31:0] held;
    run_op("R7", 32'h0010_0020, 32'h0030_0040, 1'b0, 1'b0);
    held = res_data;
    issue(32'h8000_8000, 32'h8000_8000, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7", "data held", res_data, held);
    chk("R6", "no valid when idle", {31'b0, res_valid}, 32'd0);
    chk("R7", "no flag from idle operands", {31'b0, ovf_sticky}, 32'd0);
    issue(32'h1234_5678, 32'h9ABC_DEF0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R7", "data still held", res_data, held);
  endtask

  task automatic t_overflow();
    run_op("R8", 32'h8000_8000, 32'h8000_8000, 1'b0, 1'b0);
    chk("R8", "wrapped sum", res_data, 32'h8000_0000);
    chk("R8", "flag set", {31'b0, ovf_sticky}, 32'd1);
    run_op("R9", 32'h0001_0001, 32'h0001_0001, 1'b0, 1'b0);
    chk("R9", "flag kept", {31'b0, ovf_sticky}, 32'd1);
    issue('0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9", "flag kept idle", {31'b0, ovf_sticky}, 32'd1);
  endtask

  task automatic t_clear();
    issue('0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10", "clear alone", {31'b0, ovf_sticky}, 32'd0);
    run_op("R8", 32'h8000_8000, 32'h8000_8000, 1'b0, 1'b1);
    chk("R8", "flag set with exchange", {31'b0, ovf_sticky}, 32'd1);
    issue(32'h8000_8000, 32'h8000_8000, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R10", "set beats clear", {31'b0, ovf_sticky}, 32'd1);
    issue(32'h0002_0002, 32'h0002_0002, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R10", "clear with plain sum", {31'b0, ovf_sticky}, 32'd0);
  endtask

  task automatic t_sub_extreme();
    run_op("R11", 32'h8000_8000, 32'h7FFF_8000, 1'b1, 1'b0);
    chk("R11", "extreme diff value", res_data, 32'h7FFF_8000);
    chk("R11", "no flag plain", {31'b0, ovf_sticky}, 32'd0);
    run_op("R11", 32'h8000_8000, 32'h8000_8000, 1'b1, 1'b1);
    chk("R11", "no flag cross", {31'b0, ovf_sticky}, 32'd0);
  endtask

  initial begin
    n_checks = 0;
    n_fail = 0;
    t_reset();
    t_add_plain();
    t_add_xchg();
    t_sub_plain();
    t_sub_xchg();
    t_hold();
    t_overflow();
    t_clear();
    t_sub_extreme();
    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule